// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

A mailbox peripheral that carries short messages between a host processor and an embedded processor sharing one clock. There is one lane in each direction. A lane holds a message store of 32 words (128 bytes) and a 32-bit doorbell word. The sender fills its outbound store, then writes its outbound doorbell with the busy flag (bit 31) set. The receiver sees the ring through a status bit and an interrupt. It reads the header and the message words, then writes its inbound doorbell with bit 31 low to hand the lane back. That release sets a "consumed" status bit on the sender's side, which can interrupt the sender.

Both sides see the same register map on a synchronous port (valid, write enable, word address, write data). Read data appears one cycle after the request. Word addresses 0 to 31 reach the message store: a write goes to the caller's outbound lane and a read comes from its inbound lane. Address 32 is the outbound doorbell, 33 the inbound doorbell, 34 the status word, 35 the interrupt enable word and 36 the sticky error flag. The doorbell header packs a byte count in bits 9:0, a protocol code in bits 13:10, a command code in bits 19:16 and option bits in 30:29. The block stores the header whole and checks only the byte count and the busy flag.

Top module: `mbox_bridge`

## Requirements
- R1: After reset every doorbell, status bit, enable bit and error flag is zero, every message word reads as zero, and both interrupt lines are low.
- R2: A sender's write to word address 0..31 while its outbound busy flag is clear is stored, and the receiver reads it back at the same address, with rdata valid on the cycle after the read request.
- R3: A sender write to address 32 with bit 31 set, while that lane is not busy, stores the word. The receiver then reads it at address 33 and sees status bit 0 set.
- R4: A receiver write to address 33 with bit 31 clear, while the lane is busy, clears only bit 31 of that doorbell and sets bit 8 of the sender's status word (address 34).
- R5: Each interrupt line is high exactly when (status bit 0 and enable bit 0) or (status bit 8 and enable bit 8), with the enable word at address 35.
- R6: Writing a 1 to bit 8 of address 34 clears the consumed bit. Status bit 0 follows the inbound busy flag and is not changed by writes.
- R7: While a lane is busy, its sender's writes to the message store or to address 32 change nothing, and they set the sender's error flag (address 36, bit 0). The flag stays set until a 1 is written to bit 0 of address 36.
- R8: A doorbell write with bit 31 set and a byte count (bits 9:0) above 128 is refused: the lane stays idle and the sender's error flag sets.
- R9: The header fields (count 9:0, protocol 13:10, command 19:16, options 30:29) reach the receiver bit for bit.
- R10: The lanes are independent and share one map: an embedded-to-host exchange works the same way as a host-to-embedded one, with the roles swapped.
- R11: If a release sets the consumed bit in the same cycle that the sender clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_vld | input | 1 | Host request valid |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 6 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after request |
| h_irq | output | 1 | Interrupt to host |
| e_vld | input | 1 | Embedded request valid |
| e_we | input | 1 | Embedded write (1) or read (0) |
| e_addr | input | 6 | Embedded word address |
| e_wdata | input | 32 | Embedded write data |
| e_rdata | output | 32 | Embedded read data, one cycle after request |
| e_irq | output | 1 | Interrupt to embedded processor |

## Verification
The assertions assume that write enable and address are only sampled while valid is high, and that reset is held for at least one clock edge before any traffic. They also assume that a release is the only thing that can clear a busy flag, so nothing else may write the doorbell words. The stimulus drives every request for exactly one cycle, changes inputs only on falling edges, and keeps valid low during reset. Byte counts above 128 and writes to a busy lane are sent on purpose, so the refusal paths are exercised rather than avoided.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // register offsets above the message window
    localparam int OFS_DB_OUT = 0;
    localparam int OFS_DB_IN  = 1;
    localparam int OFS_STAT   = 2;
    localparam int OFS_MASK   = 3;
    localparam int OFS_ERR    = 4;
    // bit positions (doorbell header and status)
    localparam int BUSY_BIT    = 31;
    localparam int LEN_MSB     = 9;
    localparam int ST_IN_BIT   = 0;
    localparam int ST_DONE_BIT = 8;
    localparam int ERR_BIT     = 0;
endpackage

// File: rtl/mbox_lane.sv
module mbox_lane
    import mbox_pkg::*;
#(
    parameter int NW        = 32,
    parameter int DW        = 32,
    parameter int AW        = 6,
    parameter int MAX_BYTES = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s_vld,
    input  logic                   s_we,
    input  logic [AW-1:0]          s_addr,
    input  logic [DW-1:0]          s_wdata,
    input  logic                   r_vld,
    input  logic                   r_we,
    input  logic [AW-1:0]          r_addr,
    input  logic [DW-1:0]          r_wdata,
    output logic [NW-1:0][DW-1:0]  msg_o,
    output logic [DW-1:0]          db_o,
    output logic                   done_o,
    output logic                   err_o
);
    localparam int IDXW = $clog2(NW);
    localparam logic [AW-1:0] A_DB_OUT = AW'(NW + OFS_DB_OUT);
    localparam logic [AW-1:0] A_DB_IN  = AW'(NW + OFS_DB_IN);
    localparam logic [AW-1:0] A_STAT   = AW'(NW + OFS_STAT);
    localparam logic [AW-1:0] A_ERR    = AW'(NW + OFS_ERR);
    localparam logic [LEN_MSB:0] LEN_LIM = (LEN_MSB+1)'(MAX_BYTES);

    typedef struct packed {
        logic [NW-1:0][DW-1:0] msg;
        logic [DW-1:0]         db;
        logic                  done;
        logic                  err;
    } lane_t;

    lane_t st_d, st_q;
    logic  s_wr, r_wr, busy, s_msg;
    logic  unused_rbits;

    assign unused_rbits = ^r_wdata;

    always_comb begin
        st_d  = st_q;
        s_wr  = s_vld && s_we;
        r_wr  = r_vld && r_we;
        busy  = st_q.db[BUSY_BIT];
        s_msg = (s_addr < AW'(NW));

        // clears first so a same-cycle set wins
        if (s_wr && s_addr == A_STAT && s_wdata[ST_DONE_BIT])
            st_d.done = 1'b0;
        if (s_wr && s_addr == A_ERR && s_wdata[ERR_BIT])
            st_d.err = 1'b0;

        if (s_wr && s_msg) begin
            if (busy) st_d.err = 1'b1;
            else      st_d.msg[s_addr[IDXW-1:0]] = s_wdata;
        end

        if (s_wr && s_addr == A_DB_OUT) begin
            if (busy)
                st_d.err = 1'b1;
            else if (s_wdata[BUSY_BIT] && s_wdata[LEN_MSB:0] > LEN_LIM)
                st_d.err = 1'b1;
            else
                st_d.db = s_wdata;
        end

        if (r_wr && r_addr == A_DB_IN && !r_wdata[BUSY_BIT] && busy) begin
            st_d.db[BUSY_BIT] = 1'b0;
            st_d.done         = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_o  = st_q.msg;
    assign db_o   = st_q.db;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;
endmodule

// File: rtl/mbox_port.sv
module mbox_port
    import mbox_pkg::*;
#(
    parameter int NW = 32,
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic [NW-1:0][DW-1:0]  in_msg,
    input  logic [DW-1:0]          in_db,
    input  logic [DW-1:0]          out_db,
    input  logic                   out_done,
    input  logic                   out_err,
    output logic [DW-1:0]          rdata,
    output logic                   irq
);
    localparam int IDXW = $clog2(NW);
    localparam logic [AW-1:0] A_DB_OUT = AW'(NW + OFS_DB_OUT);
    localparam logic [AW-1:0] A_DB_IN  = AW'(NW + OFS_DB_IN);
    localparam logic [AW-1:0] A_STAT   = AW'(NW + OFS_STAT);
    localparam logic [AW-1:0] A_MASK   = AW'(NW + OFS_MASK);
    localparam logic [AW-1:0] A_ERR    = AW'(NW + OFS_ERR);

    typedef struct packed {
        logic          en_in;
        logic          en_done;
        logic [DW-1:0] rdata;
    } port_t;

    port_t         st_d, st_q;
    logic [DW-1:0] stat_w, mask_w, err_w;
    logic          unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        stat_w = '0;
        stat_w[ST_IN_BIT]   = in_db[BUSY_BIT];
        stat_w[ST_DONE_BIT] = out_done;
        mask_w = '0;
        mask_w[ST_IN_BIT]   = st_q.en_in;
        mask_w[ST_DONE_BIT] = st_q.en_done;
        err_w = '0;
        err_w[ERR_BIT] = out_err;

        st_d = st_q;
        if (vld && we && addr == A_MASK) begin
            st_d.en_in   = wdata[ST_IN_BIT];
            st_d.en_done = wdata[ST_DONE_BIT];
        end
        if (vld && !we) begin
            if (addr < AW'(NW))
                st_d.rdata = in_msg[addr[IDXW-1:0]];
            else begin
                case (addr)
                    A_DB_OUT: st_d.rdata = out_db;
                    A_DB_IN:  st_d.rdata = in_db;
                    A_STAT:   st_d.rdata = stat_w;
                    A_MASK:   st_d.rdata = mask_w;
                    A_ERR:    st_d.rdata = err_w;
                    default:  st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign irq   = (in_db[BUSY_BIT] && st_q.en_in) || (out_done && st_q.en_done);
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
    parameter int NW        = 32,
    parameter int DW        = 32,
    parameter int MAX_BYTES = 128,
    localparam int AW       = $clog2(NW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_vld,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_irq,
    input  logic          e_vld,
    input  logic          e_we,
    input  logic [AW-1:0] e_addr,
    input  logic [DW-1:0] e_wdata,
    output logic [DW-1:0] e_rdata,
    output logic          e_irq
);
    // side 0 = host, side 1 = embedded; lane g carries side g -> side 1-g
    logic [1:0]                   sd_vld, sd_we, sd_irq, lane_done, lane_err;
    logic [1:0][AW-1:0]           sd_addr;
    logic [1:0][DW-1:0]           sd_wdata, sd_rdata, lane_db;
    logic [1:0][NW-1:0][DW-1:0]   lane_msg;

    assign sd_vld   = {e_vld, h_vld};
    assign sd_we    = {e_we, h_we};
    assign sd_addr  = {e_addr, h_addr};
    assign sd_wdata = {e_wdata, h_wdata};

    for (genvar g = 0; g < 2; g++) begin : g_side
        mbox_lane #(.NW(NW), .DW(DW), .AW(AW), .MAX_BYTES(MAX_BYTES)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_vld   (sd_vld[g]),
            .s_we    (sd_we[g]),
            .s_addr  (sd_addr[g]),
            .s_wdata (sd_wdata[g]),
            .r_vld   (sd_vld[1-g]),
            .r_we    (sd_we[1-g]),
            .r_addr  (sd_addr[1-g]),
            .r_wdata (sd_wdata[1-g]),
            .msg_o   (lane_msg[g]),
            .db_o    (lane_db[g]),
            .done_o  (lane_done[g]),
            .err_o   (lane_err[g])
        );
        mbox_port #(.NW(NW), .DW(DW), .AW(AW)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld      (sd_vld[g]),
            .we       (sd_we[g]),
            .addr     (sd_addr[g]),
            .wdata    (sd_wdata[g]),
            .in_msg   (lane_msg[1-g]),
            .in_db    (lane_db[1-g]),
            .out_db   (lane_db[g]),
            .out_done (lane_done[g]),
            .out_err  (lane_err[g]),
            .rdata    (sd_rdata[g]),
            .irq      (sd_irq[g])
        );
    end

    assign h_rdata = sd_rdata[0];
    assign e_rdata = sd_rdata[1];
    assign h_irq   = sd_irq[0];
    assign e_irq   = sd_irq[1];
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk
    import mbox_pkg::*;
#(
    parameter int NW        = 32,
    parameter int DW        = 32,
    parameter int AW        = 6,
    parameter int MAX_BYTES = 128
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 sd_vld,
    input logic [1:0]                 sd_we,
    input logic [1:0][AW-1:0]         sd_addr,
    input logic [1:0][DW-1:0]         sd_wdata,
    input logic [1:0]                 sd_irq,
    input logic [1:0][DW-1:0]         lane_db,
    input logic [1:0]                 lane_done,
    input logic [1:0]                 lane_err,
    input logic [1:0][NW-1:0][DW-1:0] lane_msg
);
    localparam logic [AW-1:0] A_ERR = AW'(NW + OFS_ERR);

    for (genvar g = 0; g < 2; g++) begin : g_chk
        logic err_clr;
        assign err_clr = sd_vld[g] && sd_we[g] && sd_addr[g] == A_ERR && sd_wdata[g][ERR_BIT];

        // R4: a busy flag only drops together with the consumed bit rising
        p_release_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lane_db[g][BUSY_BIT]) |-> lane_done[g]);
        // R4: the consumed bit only rises on a release
        p_done_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_done[g]) |-> $fell(lane_db[g][BUSY_BIT]));
        // R8: a lane only turns busy with a legal byte count
        p_ring_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_db[g][BUSY_BIT]) |-> lane_db[g][LEN_MSB:0] <= (LEN_MSB+1)'(MAX_BYTES));
        // R7: message store frozen while busy
        p_msg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
            lane_db[g][BUSY_BIT] |=> $stable(lane_msg[g]));
        // R7: error flag sticky until cleared
        p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            lane_err[g] && !err_clr |=> lane_err[g]);
        // R5: an interrupt always has a pending source
        p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
            sd_irq[g] |-> (lane_db[1-g][BUSY_BIT] || lane_done[g]));
    end
endmodule

bind mbox_bridge mbox_bridge_chk #(.NW(NW), .DW(DW), .AW(AW), .MAX_BYTES(MAX_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_vld    (sd_vld),
    .sd_we     (sd_we),
    .sd_addr   (sd_addr),
    .sd_wdata  (sd_wdata),
    .sd_irq    (sd_irq),
    .lane_db   (lane_db),
    .lane_done (lane_done),
    .lane_err  (lane_err),
    .lane_msg  (lane_msg)
);

// File: tb/test_mbox_bridge.sv
module test_mbox_bridge;
    localparam logic [5:0] A_DBO = 6'd32, A_DBI = 6'd33, A_ST = 6'd34, A_MK = 6'd35, A_ER = 6'd36;
    localparam int NVEC = 4;
    // header: busy | options | rsvd | command | rsvd | protocol | byte count
    localparam logic [31:0] VEC_HDR [NVEC] = '{
        {1'b1, 2'd2, 9'd0, 4'd3, 2'd0, 4'd5, 10'd128},
        {1'b1, 2'd0, 9'd0, 4'd9, 2'd0, 4'd1, 10'd4},
        {1'b1, 2'd3, 9'd0, 4'd15, 2'd0, 4'd15, 10'd0},
        {1'b1, 2'd1, 9'd0, 4'd6, 2'd0, 4'd10, 10'd61}
    };
    localparam logic [15:0] VEC_SEED [NVEC] = '{16'hA5A5, 16'h1234, 16'h0F0F, 16'hBEEF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] vld = '0, we = '0;
    logic [5:0] addr [2];
    logic [31:0] wdata [2];
    logic [31:0] rdata [2];
    logic h_irq, e_irq;
    int n_chk = 0, n_bad = 0;
    logic [31:0] rv, hdr;

    always #5 clk = ~clk;

    mbox_bridge i_mbox_bridge (
        .clk(clk), .rst_n(rst_n),
        .h_vld(vld[0]), .h_we(we[0]), .h_addr(addr[0]), .h_wdata(wdata[0]),
        .h_rdata(rdata[0]), .h_irq(h_irq),
        .e_vld(vld[1]), .e_we(we[1]), .e_addr(addr[1]), .e_wdata(wdata[1]),
        .e_rdata(rdata[1]), .e_irq(e_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int s, logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        vld[s] = 1'b1; we[s] = 1'b1; addr[s] = a; wdata[s] = d;
        @(negedge clk);
        vld[s] = 1'b0; we[s] = 1'b0;
    endtask

    task automatic wr2(logic [5:0] a0, logic [31:0] d0, logic [5:0] a1, logic [31:0] d1);
        @(negedge clk);
        vld = 2'b11; we = 2'b11; addr[0] = a0; wdata[0] = d0; addr[1] = a1; wdata[1] = d1;
        @(negedge clk);
        vld = 2'b00; we = 2'b00;
    endtask

    task automatic rd(int s, logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        vld[s] = 1'b1; we[s] = 1'b0; addr[s] = a;
        @(negedge clk);
        vld[s] = 1'b0;
        d = rdata[s];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on both sides
        for (int s = 0; s < 2; s++) begin
            rd(s, 6'd0, rv);  chk("R1 msg0", rv, 0);
            rd(s, 6'd31, rv); chk("R1 msg31", rv, 0);
            rd(s, A_DBO, rv); chk("R1 db_out", rv, 0);
            rd(s, A_DBI, rv); chk("R1 db_in", rv, 0);
            rd(s, A_ST, rv);  chk("R1 status", rv, 0);
            rd(s, A_MK, rv);  chk("R1 mask", rv, 0);
            rd(s, A_ER, rv);  chk("R1 err", rv, 0);
        end
        chk("R1 irqs", {30'd0, e_irq, h_irq}, 0);

        wr(0, A_MK, 32'h101);
        wr(1, A_MK, 32'h101);
        rd(1, A_MK, rv); chk("R5 mask readback", rv, 32'h101);

        // table walk: host -> embedded exchanges
        for (int v = 0; v < NVEC; v++) begin
            hdr = VEC_HDR[v];
            for (int i = 0; i < (int'(hdr[9:0]) + 3) / 4; i++)
                wr(0, 6'(i), {VEC_SEED[v], 16'(i)});
            wr(0, A_DBO, hdr);
            chk("R3 e_irq on ring", {31'd0, e_irq}, 1);
            rd(1, A_ST, rv);  chk("R3 e status", rv, 32'h1);
            rd(1, A_DBI, rv); chk("R9 header", rv, hdr);
            for (int i = 0; i < (int'(hdr[9:0]) + 3) / 4; i++) begin
                rd(1, 6'(i), rv); chk("R2 msg word", rv, {VEC_SEED[v], 16'(i)});
            end
            wr(1, A_DBI, hdr & 32'h7FFF_FFFF);
            chk("R5 e_irq after release", {31'd0, e_irq}, 0);
            chk("R5 h_irq on done", {31'd0, h_irq}, 1);
            rd(0, A_ST, rv);  chk("R4 h status", rv, 32'h100);
            rd(1, A_DBI, rv); chk("R4 busy only", rv, hdr & 32'h7FFF_FFFF);
            wr(0, A_ST, 32'h100);
            chk("R6 w1c irq", {31'd0, h_irq}, 0);
            rd(0, A_ST, rv);  chk("R6 w1c status", rv, 0);
        end

        // R7: writes while busy are dropped, error sticky
        wr(0, 6'd0, 32'h1111_0000);
        hdr = {1'b1, 21'd0, 10'd8};
        wr(0, A_DBO, hdr);
        wr(0, 6'd0, 32'h2222_0000);
        rd(1, 6'd0, rv);  chk("R7 msg kept", rv, 32'h1111_0000);
        rd(0, A_ER, rv);  chk("R7 err set", rv, 1);
        wr(0, A_DBO, {1'b1, 21'd7, 10'd4});
        rd(1, A_DBI, rv); chk("R7 db kept", rv, hdr);
        wr(0, A_ER, 32'h0);
        rd(0, A_ER, rv);  chk("R7 err sticky", rv, 1);
        wr(0, A_ER, 32'h1);
        rd(0, A_ER, rv);  chk("R7 err cleared", rv, 0);

        // R6: status bit 0 not writable
        wr(1, A_ST, 32'h101);
        rd(1, A_ST, rv);  chk("R6 bit0 ro", rv, 32'h1);

        // R5: mask gating
        wr(1, A_MK, 32'h0);
        chk("R5 masked", {31'd0, e_irq}, 0);
        wr(1, A_MK, 32'h1);
        chk("R5 unmasked", {31'd0, e_irq}, 1);

        // R11: release and W1C in the same cycle
        wr(1, A_DBI, 32'h0);
        wr(0, A_DBO, hdr);
        wr2(A_ST, 32'h100, A_DBI, 32'h0);
        rd(0, A_ST, rv);  chk("R11 set wins", rv, 32'h100);
        wr(0, A_ST, 32'h100);
        rd(0, A_ST, rv);  chk("R11 cleared", rv, 0);

        // R8: oversized byte count refused
        wr(0, A_DBO, {1'b1, 21'd0, 10'd129});
        rd(1, A_ST, rv);  chk("R8 not rung", rv, 0);
        rd(0, A_ER, rv);  chk("R8 err", rv, 1);
        rd(1, A_DBI, rv); chk("R8 db unchanged", rv, hdr & 32'h7FFF_FFFF);
        wr(0, A_ER, 32'h1);

        // R10: embedded -> host direction
        wr(1, A_MK, 32'h101);
        wr(1, 6'd5, 32'hC0DE_0005);
        hdr = {1'b1, 2'd1, 9'd0, 4'd2, 2'd0, 4'd3, 10'd24};
        wr(1, A_DBO, hdr);
        chk("R10 h_irq", {31'd0, h_irq}, 1);
        rd(0, 6'd5, rv);  chk("R10 msg", rv, 32'hC0DE_0005);
        rd(0, A_DBI, rv); chk("R10 header", rv, hdr);
        rd(0, A_ST, rv);  chk("R10 h status", rv, 32'h1);
        wr(0, A_DBI, 32'h0);
        rd(1, A_ST, rv);  chk("R10 e done", rv, 32'h100);
        chk("R10 e_irq done", {31'd0, e_irq}, 1);
        wr(1, A_ST, 32'h100);
        chk("R10 e_irq cleared", {31'd0, e_irq}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule